// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel: a horizontal sync, a vertical sync, a data-enable, and the raw position counters within the line and within the frame. It advances by one pixel on each cycle where the externally supplied pixel-enable strobe is high. Software programs four timing words and a control word through a simple single-cycle write port. Each timing word packs two fields of 16 bits. Most fields hold the length minus one, but the vertical back porch is stored as the plain count.

A line runs through sync, then back porch, then active pixels, then front porch. A frame runs through the same four phases, counted in lines. New timing words are held in a pending copy. That copy moves into the working copy only when the last pixel of a frame is accepted, so no frame ever mixes old and new parameters. At that same frame boundary a sticky start-of-frame flag is set. It reaches the interrupt output only while the interrupt is enabled. The interrupt is enabled and disabled by writing to two separate addresses, and the flag is cleared by reading the status address.

Top module: `lcdt_timing_gen`

## Requirements
- R1: Word 0 (sync) holds horizontal sync width minus one in bits 15:0 and vertical sync width minus one in bits 31:16.
- R2: Word 1 (vertical porch) holds vertical front porch minus one in bits 15:0 and the vertical back porch as a plain count in bits 31:16; a value of 0 gives no back-porch lines.
- R3: Word 2 (horizontal porch) holds horizontal front porch minus one in bits 15:0 and horizontal back porch minus one in bits 31:16. Word 3 (size) holds active width minus one in bits 15:0 and active height minus one in bits 31:16.
- R4: `h_cnt` advances by one only on cycles with `pix_en` high. It wraps to 0 after sync+back+active+front pixels. `v_cnt` advances only when `h_cnt` wraps, and it wraps after the vertical total in lines. Both counters hold while `pix_en` is low. `hsync` and `vsync` are asserted while the counter is in its sync phase, which comes first.
- R5: `de` is high only when `h_cnt` is inside the horizontal active phase and `v_cnt` is inside the vertical active phase.
- R6: Control word 4 has two bits. Bit 0 makes `hsync` active-low and bit 1 makes `vsync` active-low. A write to it affects the outputs from the next cycle.
- R7: Writes to words 0 to 3 take effect only at the edge where the last pixel of a frame is accepted with `pix_en` high. Until then the running frame keeps its parameters.
- R8: The start-of-frame flag (status bit 0) is set at every frame boundary. It stays set until it is read, and it is not set by reset.
- R9: Writing 1 in bit 0 to address 5 enables the interrupt, and writing 1 in bit 0 to address 6 disables it. A write with bit 0 clear to either address has no effect. `irq` is the flag gated by the enable.
- R10: A read of address 7 returns {enable, flag} in bits 1:0 and clears the flag at that edge, unless a frame boundary sets it at the same edge.
- R11: After reset the counters are 0, the flag, the enable and both polarity bits are 0, and all timing fields are 0, which gives 4-pixel lines and 3-line frames.
- R12: A read of addresses 0 to 4 returns the pending value of that word. Addresses 5 and 6 read as 0, and `rd_data` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| h_cnt | output | 18 | Pixel position within line |
| v_cnt | output | 18 | Line position within frame |
| irq | output | 1 | Start-of-frame interrupt |

## Verification
The assertions take for granted that `pix_en`, the write port and the read port are driven with settled values between clock edges. They also assume that the internal reset has been released before any access is made. The stimulus changes every input just after the falling edge. It keeps all accesses out of the reset window and switches `pix_en` between three patterns: always high, every other cycle and pseudo-random. These patterns test that the counters hold on idle cycles. Timing words are rewritten in the middle of a frame, so that the boundary rule is tested with both old and new values in flight.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int unsigned NWORDS = 4;

  typedef enum logic [2:0] {
    A_SYNC    = 3'd0,
    A_VPORCH  = 3'd1,
    A_HPORCH  = 3'd2,
    A_SIZE    = 3'd3,
    A_CTRL    = 3'd4,
    A_IRQ_SET = 3'd5,
    A_IRQ_CLR = 3'd6,
    A_STATUS  = 3'd7
  } lcdt_addr_e;
endpackage

// File: rtl/lcdt_rst_sync.sv
module lcdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/lcdt_cfg.sv
module lcdt_cfg
  import lcdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  input  logic                 frame_end,
  output logic [NWORDS*DW-1:0] act_flat,
  output logic                 hpol,
  output logic                 vpol,
  output logic                 sof_flag,
  output logic                 irq_en,
  output logic [DW-1:0]        rd_data
);
  logic [NWORDS*DW-1:0] pend_flat;

  // Pending and working copies of the timing words
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [DW-1:0] pend_d, pend_q, act_d, act_q;

    always_comb begin
      pend_d = pend_q;
      if (wr_en && (wr_addr == AW'(i))) pend_d = wr_data;
    end

    always_comb begin
      act_d = act_q;
      if (frame_end) act_d = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        pend_q <= pend_d;
        act_q  <= act_d;
      end
    end

    assign pend_flat[i*DW +: DW] = pend_q;
    assign act_flat[i*DW +: DW]  = act_q;
  end

  // Polarity, interrupt enable and sticky flag
  logic [1:0] pol_d, pol_q;
  logic       en_d, en_q;
  logic       sof_d, sof_q;
  logic       stat_rd;

  assign stat_rd = rd_en && (rd_addr == AW'(A_STATUS));

  always_comb begin
    pol_d = pol_q;
    en_d  = en_q;
    sof_d = sof_q;
    if (wr_en && (wr_addr == AW'(A_CTRL)))                  pol_d = wr_data[1:0];
    if (wr_en && (wr_addr == AW'(A_IRQ_SET)) && wr_data[0]) en_d  = 1'b1;
    if (wr_en && (wr_addr == AW'(A_IRQ_CLR)) && wr_data[0]) en_d  = 1'b0;
    if (stat_rd)   sof_d = 1'b0;
    if (frame_end) sof_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 2'b00;
      en_q  <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      pol_q <= pol_d;
      en_q  <= en_d;
      sof_q <= sof_d;
    end
  end

  assign hpol     = pol_q[0];
  assign vpol     = pol_q[1];
  assign irq_en   = en_q;
  assign sof_flag = sof_q;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_addr < AW'(NWORDS)) begin
        rd_data = pend_flat[rd_addr*DW +: DW];
      end else if (rd_addr == AW'(A_CTRL)) begin
        rd_data = {{(DW-2){1'b0}}, pol_q};
      end else if (rd_addr == AW'(A_STATUS)) begin
        rd_data = {{(DW-2){1'b0}}, en_q, sof_q};
      end
    end
  end
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          in_sync,
  output logic          in_act
);
  logic [CW-1:0] act_start, act_stop, total;
  logic [CW-1:0] cnt_d, cnt_q;

  assign act_start = len_sync + len_back;
  assign act_stop  = act_start + len_act;
  assign total     = act_stop + len_front;

  assign last    = (cnt_q == total - CW'(1));
  assign in_sync = (cnt_q < len_sync);
  assign in_act  = (cnt_q >= act_start) && (cnt_q < act_stop);

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
  import lcdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  localparam int FW = DW / 2,
  localparam int CW = FW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          irq
);
  logic                 rst_sync_n;
  logic [NWORDS*DW-1:0] act_flat;
  logic                 hpol, vpol, sof_flag, irq_en;
  logic                 h_last, v_last, h_sync_ph, v_sync_ph, h_act, v_act;
  logic                 frame_end;

  lcdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcdt_cfg #(.DW(DW), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .frame_end (frame_end),
    .act_flat  (act_flat),
    .hpol      (hpol),
    .vpol      (vpol),
    .sof_flag  (sof_flag),
    .irq_en    (irq_en),
    .rd_data   (rd_data)
  );

  function automatic logic [CW-1:0] widen(input logic [FW-1:0] f, input logic biased);
    return {2'b00, f} + (biased ? CW'(1) : CW'(0));
  endfunction

  logic [DW-1:0] w_sync, w_vp, w_hp, w_size;
  assign w_sync = act_flat[A_SYNC*DW   +: DW];
  assign w_vp   = act_flat[A_VPORCH*DW +: DW];
  assign w_hp   = act_flat[A_HPORCH*DW +: DW];
  assign w_size = act_flat[A_SIZE*DW   +: DW];

  logic [CW-1:0] hs_len, hb_len, ha_len, hf_len;
  logic [CW-1:0] vs_len, vb_len, va_len, vf_len;

  assign hs_len = widen(w_sync[FW-1:0],  1'b1);
  assign vs_len = widen(w_sync[DW-1:FW], 1'b1);
  assign vf_len = widen(w_vp[FW-1:0],    1'b1);
  assign vb_len = widen(w_vp[DW-1:FW],   1'b0);
  assign hf_len = widen(w_hp[FW-1:0],    1'b1);
  assign hb_len = widen(w_hp[DW-1:FW],   1'b1);
  assign ha_len = widen(w_size[FW-1:0],  1'b1);
  assign va_len = widen(w_size[DW-1:FW], 1'b1);

  lcdt_axis #(.CW(CW)) u_h (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (pix_en),
    .len_sync  (hs_len),
    .len_back  (hb_len),
    .len_act   (ha_len),
    .len_front (hf_len),
    .cnt       (h_cnt),
    .last      (h_last),
    .in_sync   (h_sync_ph),
    .in_act    (h_act)
  );

  lcdt_axis #(.CW(CW)) u_v (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (pix_en && h_last),
    .len_sync  (vs_len),
    .len_back  (vb_len),
    .len_act   (va_len),
    .len_front (vf_len),
    .cnt       (v_cnt),
    .last      (v_last),
    .in_sync   (v_sync_ph),
    .in_act    (v_act)
  );

  assign frame_end = pix_en && h_last && v_last;
  assign hsync     = h_sync_ph ^ hpol;
  assign vsync     = v_sync_ph ^ vpol;
  assign de        = h_act && v_act;
  assign irq       = sof_flag && irq_en;
endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk #(
  parameter int CW = 18,
  parameter int AW = 3,
  parameter int XW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          h_last,
  input logic          v_last,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] v_cnt,
  input logic [XW-1:0] act_flat,
  input logic          sof_flag,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr
);
  logic fend, srd;
  assign fend = pix_en && h_last && v_last;
  assign srd  = rd_en && (rd_addr == AW'(7));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_cnt) && $stable(v_cnt)));

  p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !h_last) |=> $stable(v_cnt));

  p_hwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && h_last) |=> (h_cnt == '0));

  p_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fend |=> $stable(act_flat));

  p_sof_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fend |=> sof_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_flag && !srd) |=> sof_flag);

  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (srd && !fend) |=> !sof_flag);
endmodule

bind lcdt_timing_gen lcdt_timing_chk #(.CW(CW), .AW(AW), .XW(lcdt_pkg::NWORDS*DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pix_en   (pix_en),
  .h_last   (h_last),
  .v_last   (v_last),
  .h_cnt    (h_cnt),
  .v_cnt    (v_cnt),
  .act_flat (act_flat),
  .sof_flag (sof_flag),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr)
);

// File: tb/tb_lcdt_timing_gen.sv
module tb_lcdt_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en, wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        hsync, vsync, de, irq;
  logic [17:0] h_cnt, v_cnt;

  always #2 clk = ~clk;

  lcdt_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .de(de),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R11";
  bit    done = 0;
  int    pmode = 0;
  int    cyc_n = 0;

  // Behavioural reference state
  int unsigned pend[4];
  int unsigned act[4];
  int hc, vc, rs_cnt;
  bit flag, ien, hp, vp;

  function automatic int fld(int unsigned w, int hi, int bias);
    return (hi ? (w >> 16) : (w & 32'hFFFF)) + bias;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_cnt = 0;
      foreach (pend[i]) begin pend[i] = 0; act[i] = 0; end
      hc = 0; vc = 0; flag = 0; ien = 0; hp = 0; vp = 0;
    end else if (rs_cnt < 2) begin
      rs_cnt++;
    end else begin
      int hs, hb, ha, hf, vs, vb, va, vf, ht, vt;
      bit fe;
      int unsigned old_pend[4];
      hs = fld(act[0], 0, 1); vs = fld(act[0], 1, 1);
      vf = fld(act[1], 0, 1); vb = fld(act[1], 1, 0);
      hf = fld(act[2], 0, 1); hb = fld(act[2], 1, 1);
      ha = fld(act[3], 0, 1); va = fld(act[3], 1, 1);
      ht = hs + hb + ha + hf; vt = vs + vb + va + vf;
      fe = pix_en && (hc == ht - 1) && (vc == vt - 1);
      old_pend = pend;
      if (rd_en && rd_addr == 3'd7) flag = 0;
      if (fe) flag = 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0, 3'd1, 3'd2, 3'd3: pend[wr_addr] = wr_data;
          3'd4: begin hp = wr_data[0]; vp = wr_data[1]; end
          3'd5: if (wr_data[0]) ien = 1;
          3'd6: if (wr_data[0]) ien = 0;
          default: ;
        endcase
      end
      if (fe) act = old_pend;
      if (pix_en) begin
        if (hc == ht - 1) begin
          hc = 0;
          vc = (vc == vt - 1) ? 0 : vc + 1;
        end else hc++;
      end
    end
  end

  task automatic chk(string sig, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, sig, got, exp, $time);
    end
  endtask

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!done && $time > 0) begin
      int hs, hb, ha, vs, vb, va;
      bit e_hs, e_vs, e_de;
      longint e_rd;
      hs = fld(act[0], 0, 1); vs = fld(act[0], 1, 1);
      vb = fld(act[1], 1, 0);
      hb = fld(act[2], 1, 1);
      ha = fld(act[3], 0, 1); va = fld(act[3], 1, 1);
      e_hs = (hc < hs) ^ hp;
      e_vs = (vc < vs) ^ vp;
      e_de = (hc >= hs + hb) && (hc < hs + hb + ha) && (vc >= vs + vb) && (vc < vs + vb + va);
      e_rd = 0;
      if (rd_en) begin
        if (rd_addr < 3'd4) e_rd = pend[rd_addr];
        else if (rd_addr == 3'd4) e_rd = {vp, hp};
        else if (rd_addr == 3'd7) e_rd = {ien, flag};
      end
      chk("h_cnt", h_cnt, hc);
      chk("v_cnt", v_cnt, vc);
      chk("hsync", hsync, e_hs);
      chk("vsync", vsync, e_vs);
      chk("de", de, e_de);
      chk("irq", irq, flag && ien);
      chk("rd_data", rd_data, e_rd);
    end
  end

  task automatic cyc(bit we = 0, logic [2:0] wa = 0, logic [31:0] wd = 0,
                     bit re = 0, logic [2:0] ra = 0);
    @(negedge clk); #1;
    cyc_n++;
    case (pmode)
      0: pix_en = 1'b1;
      1: pix_en = cyc_n[0];
      default: pix_en = 1'($urandom_range(0, 1));
    endcase
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R4 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_en = 0; wr_en = 0; rd_en = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    tag = "R11"; idle(4);
    cyc(0, 0, 0, 1, 3'd7);                         // R11 status reads zero
    tag = "R4 R5 R8"; idle(60);                   // default 4x3 raster
    tag = "R1 R2 R3 R7";                          // reprogram mid-frame
    idle(5);
    cyc(1, 3'd0, 32'h0001_0001);
    idle(3);
    cyc(1, 3'd1, 32'h0001_0001);
    cyc(1, 3'd2, 32'h0002_0001);
    cyc(1, 3'd3, 32'h0003_0007);
    idle(300);
    tag = "R12";
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, a != 7, 3'(a));
    cyc(0, 0, 0, 0, 3'd2);                        // rd_en low gives zero
    tag = "R6"; pmode = 1;
    cyc(1, 3'd4, 32'h3); idle(150);
    cyc(1, 3'd4, 32'h1); idle(100);
    cyc(1, 3'd4, 32'h0); idle(40);
    tag = "R9"; pmode = 0;
    cyc(1, 3'd5, 32'h0); idle(150);               // ignored: bit 0 clear
    cyc(1, 3'd5, 32'h1); idle(150);
    cyc(1, 3'd6, 32'hFFFE); idle(20);             // ignored: bit 0 clear
    cyc(0, 0, 0, 1, 3'd7); idle(150);
    cyc(1, 3'd6, 32'h1); idle(150);
    tag = "R10 R8"; cyc(1, 3'd5, 32'h1);
    for (int k = 0; k < 120; k++) cyc(0, 0, 0, (k % 7) == 0, 3'd7);
    tag = "R2 R7"; pmode = 2;
    cyc(1, 3'd1, 32'h0000_0002); idle(400);
    tag = "R4 R5"; cyc(1, 3'd3, 32'h0002_0004);
    for (int k = 0; k < 400; k++) cyc(0, 0, 0, (k % 37) == 0, 3'd7);
    tag = "R3 R7"; pmode = 0;
    cyc(1, 3'd2, 32'h0000_0000); idle(300);
    done = 1;
    summary();
    $finish;
  end
endmodule